// File: doc/BRIEF.md
# Three-Channel Down-Counter Timer with Watchdog Reset

This block is a register-mapped timer peripheral holding three 32-bit down-counters. Channels 0 and 1 are general purpose and serve as event timers (one-shot or periodic) or as a free-running timebase. Channel 2 acts as a watchdog. Its expiry can drive a sticky reset request out of the block. Each channel owns a current-count register and a reload register. A single shared control word holds, for each channel, a run bit, a periodic bit and a tick-source select bit.

Counting is paced by two single-cycle clock-enable strobes, a system-rate tick and a fixed fast tick. Each channel picks one of them through its select bit. Every expiry latches a bit in a cause register. Software clears a cause bit by writing 0 to it; bits written as 1 keep their value. A mask register decides which cause bits reach the single interrupt line.

The register port is plain: a write takes effect on the clock edge where `bus_sel` and `bus_wr` are high, and read data is a combinational function of `bus_addr`. No data streams pass through the block, so no valid/ready handshake is used.

Top module: `tri_timer_wdog`

## Requirements
- R1: After reset every register (control 0x00, counts, reloads, cause 0x40, mask 0x44) reads 0, and both `irq` and `wdog_rst` are low.
- R2: Register map: channel n reload is at 0x10+8n and channel n count is at 0x14+8n. Control bit 3n is run n, bit 3n+1 is periodic n, bit 3n+2 is fast-tick select n, and bit 31 is watchdog reset enable. Undefined control bits read 0, and the mask holds bits [2:0].
- R3: A channel whose run bit is set decrements by one on each cycle where its selected tick is high. The fast tick is selected when the select bit is 1; otherwise the system tick is used. A stopped channel, or a tick on the unselected source, leaves the count unchanged.
- R4: On a selected tick at count 0 with the periodic bit set, the channel loads its reload value and sets its cause bit.
- R5: On a selected tick at count 0 with the periodic bit clear, the channel sets its cause bit and hardware clears its run bit. The count stays 0 and later ticks have no effect.
- R6: A bus write to a count register in the same cycle as a counting tick loads the written value. The decrement is discarded.
- R7: Writing the cause register ANDs it with the write data, so 0 clears a bit and 1 keeps it. An expiry in the same cycle still sets its bit.
- R8: `irq` is high exactly when some cause bit n and mask bit n are both 1.
- R9: An expiry of channel 2 while control bit 31 is set raises `wdog_rst`, which then stays high until reset. Channel 2 expiry with bit 31 clear leaves `wdog_rst` low.
- R10: With reload 0xFFFFFFFF in periodic mode, the count steps from 0 to 0xFFFFFFFF and then onward to 0xFFFFFFFE. Elapsed ticks therefore equal 0xFFFFFFFF minus the count, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sys | input | 1 | System-rate count strobe |
| tick_fast | input | 1 | Fixed fast-rate count strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Masked interrupt request |
| wdog_rst | output | 1 | Sticky watchdog reset request |

## Verification
The assertions assume that tick strobes and bus inputs change only between clock edges, and that each cycle carries at most one register access. The bench drives every input on the falling edge and holds it for exactly one cycle. Stimulus writes only defined register addresses. Before each scenario it stops all channels and clears the cause register, so ticks from one scenario never run a channel left over from an earlier one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register offsets
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_RLD0  = 'h10;
  localparam int unsigned OFS_CNT0  = 'h14;
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned OFS_CAUSE = 'h40;
  localparam int unsigned OFS_MASK  = 'h44;
  // control word layout
  localparam int unsigned BITS_PER_CH = 3;
  localparam int unsigned RSTEN_POS   = 31;

  function automatic int unsigned run_pos(input int unsigned ch);
    return BITS_PER_CH * ch;
  endfunction
  function automatic int unsigned per_pos(input int unsigned ch);
    return BITS_PER_CH * ch + 1;
  endfunction
  function automatic int unsigned fsel_pos(input int unsigned ch);
    return BITS_PER_CH * ch + 2;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_sys,
  input  logic             tick_fast,
  input  logic             run,
  input  logic             periodic,
  input  logic             fast_sel,
  input  logic             ld_cnt,
  input  logic             ld_rld,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic tick_sel, step, at_zero;

  assign tick_sel = fast_sel ? tick_fast : tick_sys;
  assign step     = run & tick_sel & ~ld_cnt;
  assign at_zero  = (count == '0);
  assign expire   = step & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (ld_rld) begin
      reload <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ld_cnt) begin
      count <= wdata;
    end else if (step) begin
      if (!at_zero)      count <= count - CNT_W'(1);
      else if (periodic) count <= reload;
    end
  end

  // R3: one step down per selected tick
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_sel && !ld_cnt && count != '0) |=> count == $past(count) - CNT_W'(1));

  // R4: periodic reload at zero
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_sel && !ld_cnt && count == '0 && periodic) |=> count == $past(reload));

  // R6: bus load wins
  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> count == $past(wdata));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_CH-1:0]              expire,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  counts,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  reloads,
  input  logic [NUM_CH-1:0]              cause,
  input  logic [NUM_CH-1:0]              mask,
  output logic [NUM_CH-1:0]              run,
  output logic [NUM_CH-1:0]              periodic,
  output logic [NUM_CH-1:0]              fast_sel,
  output logic                           rst_en,
  output logic [NUM_CH-1:0]              ld_cnt,
  output logic [NUM_CH-1:0]              ld_rld,
  output logic                           wr_cause,
  output logic                           wr_mask,
  output logic [DATA_W-1:0]              bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

  logic wr_en, wr_ctrl;
  logic [DATA_W-1:0] ctrl_word;

  assign wr_en    = bus_sel & bus_wr;
  assign wr_ctrl  = wr_en & (bus_addr == A_CTRL);
  assign wr_cause = wr_en & (bus_addr == A_CAUSE);
  assign wr_mask  = wr_en & (bus_addr == A_MASK);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_RLD0 + CH_STRIDE * n);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT0 + CH_STRIDE * n);
    assign ld_rld[n] = wr_en & (bus_addr == A_RLD);
    assign ld_cnt[n] = wr_en & (bus_addr == A_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run[n]      <= 1'b0;
        periodic[n] <= 1'b0;
        fast_sel[n] <= 1'b0;
      end else if (wr_ctrl) begin
        run[n]      <= bus_wdata[run_pos(n)];
        periodic[n] <= bus_wdata[per_pos(n)];
        fast_sel[n] <= bus_wdata[fsel_pos(n)];
      end else if (expire[n] && !periodic[n]) begin
        run[n] <= 1'b0;
      end
    end

    // R5: one-shot expiry stops the channel
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[n] && !periodic[n] && !wr_ctrl) |=> !run[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_en <= 1'b0;
    else if (wr_ctrl) rst_en <= bus_wdata[RSTEN_POS];
  end

  always_comb begin
    ctrl_word = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      ctrl_word[run_pos(n)]  = run[n];
      ctrl_word[per_pos(n)]  = periodic[n];
      ctrl_word[fsel_pos(n)] = fast_sel[n];
    end
    ctrl_word[RSTEN_POS] = rst_en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)  bus_rdata = ctrl_word;
    if (bus_addr == A_CAUSE) bus_rdata = DATA_W'(cause);
    if (bus_addr == A_MASK)  bus_rdata = DATA_W'(mask);
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(OFS_RLD0 + CH_STRIDE * n)) bus_rdata = reloads[n];
      if (bus_addr == ADDR_W'(OFS_CNT0 + CH_STRIDE * n)) bus_rdata = counts[n];
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned WDOG_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire,
  input  logic              wr_cause,
  input  logic              wr_mask,
  input  logic [NUM_CH-1:0] wdata,
  input  logic              rst_en,
  output logic [NUM_CH-1:0] cause,
  output logic [NUM_CH-1:0] mask,
  output logic              irq,
  output logic              wdog_rst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause <= '0;
    else if (wr_cause) cause <= (cause & wdata) | expire;
    else               cause <= cause | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_rst <= 1'b0;
    else if (expire[WDOG_IDX] && rst_en) wdog_rst <= 1'b1;
  end

  assign irq = |(cause & mask);

  // R7: an expiry always latches its cause bit
  p_cause_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((cause & $past(expire)) == $past(expire)));
  // R7: without a cause write, no bit is lost
  p_cause_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> ((cause & $past(cause)) == $past(cause)));
  // R9: armed watchdog expiry raises reset
  p_wdog_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire[WDOG_IDX] && rst_en) |=> wdog_rst);
  // R9: reset request is sticky
  p_wdog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> wdog_rst);
endmodule

// File: rtl/tri_timer_wdog.sv
module tri_timer_wdog #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WDOG_IDX = NUM_CH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sys,
  input  logic              tick_fast,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wdog_rst
);
  logic [NUM_CH-1:0] run, periodic, fast_sel, ld_cnt, ld_rld, expire;
  logic [NUM_CH-1:0] cause, mask;
  logic [NUM_CH-1:0][CNT_W-1:0] counts, reloads;
  logic rst_en, wr_cause, wr_mask;

  tmr_regs #(.NUM_CH(NUM_CH), .DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
    .counts(counts), .reloads(reloads), .cause(cause), .mask(mask),
    .run(run), .periodic(periodic), .fast_sel(fast_sel), .rst_en(rst_en),
    .ld_cnt(ld_cnt), .ld_rld(ld_rld), .wr_cause(wr_cause), .wr_mask(wr_mask),
    .bus_rdata(bus_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_fast(tick_fast),
      .run(run[n]), .periodic(periodic[n]), .fast_sel(fast_sel[n]),
      .ld_cnt(ld_cnt[n]), .ld_rld(ld_rld[n]), .wdata(bus_wdata),
      .count(counts[n]), .reload(reloads[n]), .expire(expire[n])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH), .WDOG_IDX(WDOG_IDX)) u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .wr_cause(wr_cause),
    .wr_mask(wr_mask), .wdata(bus_wdata[NUM_CH-1:0]), .rst_en(rst_en),
    .cause(cause), .mask(mask), .irq(irq), .wdog_rst(wdog_rst)
  );

  // R8: a masked-off cause never raises the interrupt
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/tri_timer_wdog_tb.sv
module tri_timer_wdog_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_sys = 1'b0, tick_fast = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, wdog_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tri_timer_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_fast(tick_fast),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic ts = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_sys = ts;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_sys = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input logic s, input logic f, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      tick_sys = s; tick_fast = f;
      @(negedge clk);
      tick_sys = 1'b0; tick_fast = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic quiesce();
    wr(8'h00, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h14, d); check("R1 count0", d, 0);
    rd(8'h20, d); check("R1 reload2", d, 0);
    rd(8'h40, d); check("R1 cause", d, 0);
    rd(8'h44, d); check("R1 mask", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wdog_rst", {31'b0, wdog_rst}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h20, 32'hCAFE0001);
    wr(8'h1C, 32'h00000055);
    wr(8'h44, 32'hFFFFFFFF);
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h20, d); check("R2 reload2", d, 32'hCAFE0001);
    rd(8'h1C, d); check("R2 count1", d, 32'h55);
    rd(8'h44, d); check("R2 mask", d, 32'h7);
    rd(8'h00, d); check("R2 ctrl", d, 32'h800001FF);
    quiesce();
  endtask

  task automatic t_count();
    logic [31:0] d;
    quiesce();
    wr(8'h14, 32'd10);
    wr(8'h00, 32'h1);
    ticks(1, 0, 3); rd(8'h14, d); check("R3 sys ticks", d, 7);
    ticks(0, 1, 2); rd(8'h14, d); check("R3 unselected fast", d, 7);
    wr(8'h00, 32'h5);
    ticks(0, 1, 2); rd(8'h14, d); check("R3 fast ticks", d, 5);
    ticks(1, 0, 1); rd(8'h14, d); check("R3 unselected sys", d, 5);
    wr(8'h00, 32'h0);
    ticks(1, 1, 2); rd(8'h14, d); check("R3 stopped", d, 5);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    quiesce();
    wr(8'h10, 32'd2);
    wr(8'h14, 32'd1);
    wr(8'h00, 32'h3);
    ticks(1, 0, 1); rd(8'h40, d); check("R4 no cause before zero", d, 0);
    ticks(1, 0, 1);
    rd(8'h14, d); check("R4 reloaded", d, 2);
    rd(8'h40, d); check("R4 cause0 set", d, 1);
    wr(8'h40, 32'hFFFFFFFF); rd(8'h40, d); check("R7 write 1 keeps", d, 1);
    wr(8'h40, 32'hFFFFFFFE); rd(8'h40, d); check("R7 write 0 clears", d, 0);
    // expiry and clear in the same cycle: count0 is 0 after two ticks
    ticks(1, 0, 2);
    wr(8'h40, 32'h0, 1'b1); rd(8'h40, d); check("R7 set wins over clear", d, 1);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    quiesce();
    wr(8'h1C, 32'd0);
    wr(8'h00, 32'h8);
    ticks(1, 0, 1);
    rd(8'h40, d); check("R5 cause1 set", d, 2);
    rd(8'h00, d); check("R5 run1 cleared", d, 0);
    wr(8'h40, 32'h0);
    ticks(1, 0, 2);
    rd(8'h40, d); check("R5 no refire", d, 0);
    rd(8'h1C, d); check("R5 count stays 0", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    quiesce();
    wr(8'h14, 32'd5);
    wr(8'h00, 32'h1);
    wr(8'h14, 32'd100, 1'b1);
    rd(8'h14, d); check("R6 write beats tick", d, 100);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    quiesce();
    wr(8'h14, 32'd0);
    wr(8'h00, 32'h1);
    ticks(1, 0, 1);
    rd(8'h40, d); check("R8 cause0 set", d, 1);
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(8'h44, 32'h2); #1 check("R8 other mask bit", {31'b0, irq}, 0);
    wr(8'h44, 32'h1); #1 check("R8 irq unmasked", {31'b0, irq}, 1);
    wr(8'h40, 32'h0); #1 check("R8 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    quiesce();
    wr(8'h18, 32'hFFFFFFFF);
    wr(8'h1C, 32'd1);
    wr(8'h00, 32'h18);
    ticks(1, 0, 2); rd(8'h1C, d); check("R10 wrap to max", d, 32'hFFFFFFFF);
    ticks(1, 0, 1); rd(8'h1C, d); check("R10 elapsed after wrap", d, 32'hFFFFFFFE);
  endtask

  task automatic t_wdog();
    logic [31:0] d;
    quiesce();
    wr(8'h24, 32'd0);
    wr(8'h00, 32'h40);
    ticks(1, 0, 1);
    rd(8'h40, d); check("R9 cause2 set", d, 4);
    check("R9 unarmed no reset", {31'b0, wdog_rst}, 0);
    wr(8'h24, 32'd1);
    wr(8'h00, 32'h80000040);
    ticks(1, 0, 1);
    check("R9 not yet expired", {31'b0, wdog_rst}, 0);
    ticks(1, 0, 1);
    check("R9 armed expiry", {31'b0, wdog_rst}, 1);
    wr(8'h00, 32'h0);
    ticks(1, 1, 2);
    check("R9 sticky", {31'b0, wdog_rst}, 1);
    do_reset();
    #1 check("R9 cleared by reset", {31'b0, wdog_rst}, 0);
  endtask

  initial begin
    t_reset();
    t_map();
    t_count();
    t_periodic();
    t_oneshot();
    t_priority();
    t_mask();
    t_wrap();
    t_wdog();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule